// File: doc/BRIEF.md
# Control Store Programming Port

This block loads microinstructions into the instruction store of a processing engine. A host reaches it through a small register write bus. It first writes the address/control register with the programming-mode bit set and a start index. It then supplies each 40-bit instruction as two writes. The first write carries the low 32 bits. The second carries an upper word whose low byte holds instruction bits 39:32.

The second write completes the instruction. The port adds two even-parity bits, one over each 20-bit half. It issues a single-cycle write of the resulting 42-bit word to the store memory and advances the index. When the index passes the last location it returns to zero. A readback of the address/control register shows the current mode and index. Clearing the mode bit ends programming.

Top module: `cs_prog_port`

## Requirements
- R1: After reset the store write strobe is low and the address/control register reads back as zero, meaning programming mode is off with index 0.
- R2: Register select encoding: 0 is the address/control register, 1 is the lower data word, 2 is the upper data word, and 3 is unused. Writing select 0 loads the programming-mode flag from bit 31 and the index from the low log2(DEPTH) bits. Reading select 0 returns the flag in bit 31 and the index in the low bits, with zeros elsewhere.
- R3: A lower-word write only stores the value in a holding register. The store write strobe stays low in the next cycle.
- R4: An upper-word write in programming mode raises the store write strobe for exactly one cycle, in the cycle after the write. In that cycle the store address equals the index before the write, bits 31:0 of the store data hold the last lower word, and bits 39:32 hold bits 7:0 of the upper word.
- R5: Store data bit 40 is the even-parity bit over instruction bits 19:0, and bit 41 is the even-parity bit over bits 39:20. Each 21-bit group therefore has an even number of ones.
- R6: Each committed instruction advances the index by one.
- R7: A commit at index DEPTH-1 sets the index to 0. The register then reads back bit 31 set with address 0, and the next commit goes to location 0.
- R8: Writing 0 to the address/control register leaves programming mode, and the register then reads back 0.
- R9: An upper-word write while programming mode is off leaves the strobe low and the index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | Register write strobe |
| csrSel | input | 2 | Register select (0 address/control, 1 lower, 2 upper) |
| csrWrData | input | 32 | Register write data |
| csrRdData | output | 32 | Combinational readback of the selected register |
| storeWe | output | 1 | Store memory write strobe |
| storeAddr | output | 13 | Store memory write address |
| storeData | output | 42 | Instruction plus two parity bits |

## Verification
Readback of the address/control register is combinational. Its new value is therefore due in the first cycle after the clock edge that takes a write. The store write strobe, address and data are registered once, so they appear in the cycle right after the edge that accepts the upper-word write, and they must be low again one cycle later. The bench drives on the falling edge and samples just before the next rising edge, so each check lands in the cycle its result is due. Random instruction words are checked against a bench parity and index model. Directed cases cover the wrap at the top of the store, writes made with programming mode off, and exit from programming mode.

// File: rtl/cs_prog_pkg.sv
package cs_prog_pkg;
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_LOW  = 2'd1;
  localparam logic [1:0] SEL_HIGH = 2'd2;

  localparam int INSN_W  = 40;
  localparam int HALF_W  = 20;
  localparam int WORD_W  = INSN_W + 2;

  typedef struct packed {
    logic latchLow;
    logic commit;
  } cs_strobe_t;

  function automatic logic evenPar(input logic [HALF_W-1:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/cs_prog_ctrl.sv
module cs_prog_ctrl
  import cs_prog_pkg::*;
#(
  parameter int DEPTH = 8192,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [1:0]    wrSel,
  input  logic          modeBit,
  input  logic [AW-1:0] wrIndex,
  output cs_strobe_t    strb,
  output logic [AW-1:0] commitAddr,
  output logic          progMode,
  output logic [AW-1:0] index
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic addrWrite;

  always_comb begin
    addrWrite     = wrEn && (wrSel == SEL_ADDR);
    strb.latchLow = wrEn && (wrSel == SEL_LOW);
    strb.commit   = wrEn && (wrSel == SEL_HIGH) && progMode;
    commitAddr    = index;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progMode <= 1'b0;
      index    <= '0;
    end else if (addrWrite) begin
      progMode <= modeBit;
      index    <= wrIndex;
    end else if (strb.commit) begin
      index <= (index == LAST) ? '0 : index + 1'b1;
    end
  end

  a_r6_auto_increment: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && index != LAST) |=> (index == $past(index) + 1'b1));

  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && index == LAST) |=> (index == '0 && progMode));

  a_r9_ignored_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_HIGH && !progMode) |=> ($stable(index) && !progMode));

  a_r8_mode_exit: assert property (@(posedge clk) disable iff (!rstN)
    (addrWrite && !modeBit) |=> !progMode);
endmodule

// File: rtl/cs_prog_datapath.sv
module cs_prog_datapath
  import cs_prog_pkg::*;
#(
  parameter int DEPTH = 8192,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cs_strobe_t        strb,
  input  logic [AW-1:0]     commitAddr,
  input  logic [31:0]       wrData,
  output logic              storeWe,
  output logic [AW-1:0]     storeAddr,
  output logic [WORD_W-1:0] storeData
);
  logic [31:0]       holdLow;
  logic [INSN_W-1:0] insn;

  always_comb insn = {wrData[7:0], holdLow};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdLow   <= '0;
      storeWe   <= 1'b0;
      storeAddr <= '0;
      storeData <= '0;
    end else begin
      if (strb.latchLow) holdLow <= wrData;
      storeWe <= strb.commit;
      if (strb.commit) begin
        storeAddr <= commitAddr;
        storeData <= {evenPar(insn[39:20]), evenPar(insn[19:0]), insn};
      end
    end
  end

  a_r5_parity_even: assert property (@(posedge clk) disable iff (!rstN)
    storeWe |-> (^storeData[19:0] == storeData[40]) && (^storeData[39:20] == storeData[41]));

  a_r3_low_no_store: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> !storeWe);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (storeWe && storeAddr == $past(commitAddr)));
endmodule

// File: rtl/cs_prog_port.sv
module cs_prog_port
  import cs_prog_pkg::*;
#(
  parameter int DEPTH = 8192,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrWrEn,
  input  logic [1:0]        csrSel,
  input  logic [31:0]       csrWrData,
  output logic [31:0]       csrRdData,
  output logic              storeWe,
  output logic [AW-1:0]     storeAddr,
  output logic [WORD_W-1:0] storeData
);
  cs_strobe_t    strb;
  logic [AW-1:0] commitAddr;
  logic          progMode;
  logic [AW-1:0] index;

  cs_prog_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(csrWrEn), .wrSel(csrSel),
    .modeBit(csrWrData[31]), .wrIndex(csrWrData[AW-1:0]),
    .strb(strb), .commitAddr(commitAddr), .progMode(progMode), .index(index)
  );

  cs_prog_datapath #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .commitAddr(commitAddr),
    .wrData(csrWrData), .storeWe(storeWe), .storeAddr(storeAddr),
    .storeData(storeData)
  );

  always_comb begin
    csrRdData = '0;
    if (csrSel == SEL_ADDR) begin
      csrRdData[AW-1:0] = index;
      csrRdData[31]     = progMode;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |=> (!storeWe && !progMode && index == '0));
endmodule

// File: tb/tb_cs_prog_port.sv
module tb_cs_prog_port;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8192;
  localparam int AW = $clog2(DEPTH);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [1:0]  csrSel = 2'd3;
  logic [31:0] csrWrData = '0;
  logic [31:0] csrRdData;
  logic        storeWe;
  logic [AW-1:0] storeAddr;
  logic [41:0] storeData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  int unsigned expIndex;
  logic [31:0] lastLow;

  cs_prog_port #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrSel(csrSel),
    .csrWrData(csrWrData), .csrRdData(csrRdData), .storeWe(storeWe),
    .storeAddr(storeAddr), .storeData(storeData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic parOf(input logic [19:0] v);
    int n = 0;
    for (int i = 0; i < 20; i++) if (v[i]) n++;
    return (n % 2) == 1;
  endfunction

  function automatic logic [41:0] expWord(input logic [31:0] lo, input logic [31:0] hi);
    logic [39:0] ins = {hi[7:0], lo};
    return {parOf(ins[39:20]), parOf(ins[19:0]), ins};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic csrWrite(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    csrWrEn = 1'b1; csrSel = sel; csrWrData = data;
    @(negedge clk);
    csrWrEn = 1'b0; csrSel = 2'd3;
  endtask

  task automatic readAddr(input string req, input logic [31:0] exp);
    csrSel = 2'd0;
    #1;
    chk(req, csrRdData, exp);
    csrSel = 2'd3;
  endtask

  task automatic commitOne(input string req, input logic [31:0] lo, input logic [31:0] hi);
    csrWrite(2'd1, lo);
    chk({req, " R3 no store on lower"}, storeWe, 1'b0);
    csrWrite(2'd2, hi);
    chk({req, " R4 strobe"}, storeWe, 1'b1);
    chk({req, " R4 addr"}, storeAddr, expIndex[AW-1:0]);
    chk({req, " R5 data+parity"}, storeData, expWord(lo, hi));
    expIndex = (expIndex == DEPTH - 1) ? 0 : expIndex + 1;
    @(negedge clk);
    chk({req, " R4 one cycle"}, storeWe, 1'b0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 strobe idle", storeWe, 1'b0);
    readAddr("R1 readback", 32'h0);

    // R9: upper write while off
    csrWrite(2'd1, 32'hDEAD_BEEF);
    csrWrite(2'd2, 32'h0000_00AA);
    chk("R9 no strobe when off", storeWe, 1'b0);
    readAddr("R9 index unchanged", 32'h0);

    // R2: enter programming mode at 0
    csrWrite(2'd0, 32'h8000_0000);
    readAddr("R2 enter mode", 32'h8000_0000);
    expIndex = 0;

    commitOne("R6 dir0", 32'h0000_0000, 32'h0000_0000);
    commitOne("R6 dir1", 32'hFFFF_FFFF, 32'h0000_00FF);
    commitOne("R6 dir2", 32'h0000_0001, 32'h0000_0080);
    readAddr("R6 index after 3", 32'h8000_0003);

    // random stream
    for (int k = 0; k < 200; k++) begin
      logic [31:0] lo = $urandom;
      logic [31:0] hi = $urandom;
      commitOne("R4 rand", lo, hi);
      if (k % 50 == 0) readAddr("R6 rand index", 32'h8000_0000 | expIndex);
    end

    // R2 index load and R7 wrap
    csrWrite(2'd0, 32'h8000_0000 | (DEPTH - 2));
    expIndex = DEPTH - 2;
    readAddr("R2 index load", 32'h8000_0000 | (DEPTH - 2));
    commitOne("R7 pre", 32'h1234_5678, 32'h0000_009A);
    commitOne("R7 last", 32'h8765_4321, 32'h0000_0011);
    readAddr("R7 wrapped readback", 32'h8000_0000);
    commitOne("R7 after wrap", 32'hCAFE_F00D, 32'h0000_0042);
    readAddr("R7 index 1", 32'h8000_0001);

    // R8 exit
    csrWrite(2'd0, 32'h0000_0000);
    readAddr("R8 exit readback", 32'h0);
    csrWrite(2'd1, 32'h1111_1111);
    csrWrite(2'd2, 32'h0000_0022);
    chk("R9 no strobe after exit", storeWe, 1'b0);
    readAddr("R9 index after exit", 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule